// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This block carries out the four single-bit operations of a processor's integer datapath: test a bit, invert it, clear it or set it. It takes the instruction word, the bit number already fetched by the surrounding pipeline, the operand value, the incoming condition flags and the addressing cost of a memory operand. One clock later it returns the updated flags, the modified operand with a write strobe, the execution cycle count and the program-counter step that the bit-number source implies.

The bit number comes from one of two places. It is either an immediate held in an extension word that follows the instruction, or the contents of a data register that the instruction names. The operand is either a data register, which is 32 bits wide, or a byte in memory. The unit decodes the instruction word to find the form and the operand type. It also exposes, combinationally, the register index fields so that the register file can be read in the same cycle. Fetching the memory operand and writing it back are handled outside the block.

Top module: `bitop_unit`

## Requirements
- R1: When the addressing-mode field (opcode bits 5:3) is 0, the operand is a 32-bit register and the bit index is the bit number modulo 32. For any other mode the operand is its low byte, the index is the bit number modulo 8, and result bits 31:8 are 0.
- R2: Flag bit 2 of the flag vector is Z. It leaves the unit as 1 exactly when the addressed bit of the operand was 0 before any change. Flag bits 4:3 and 1:0 pass through unchanged.
- R3: Operation code 1 (opcode bits 7:6) inverts the addressed bit and leaves all other operand bits as they were.
- R4: Operation code 2 forces the addressed bit to 0 and leaves all other operand bits as they were.
- R5: Operation code 3 forces the addressed bit to 1 and leaves all other operand bits as they were.
- R6: Operation code 0 (test) returns the operand unchanged and keeps the write strobe low. The other three codes raise the write strobe.
- R7: When opcode bit 8 is 0 (immediate bit number), the count is 10 for a register operand and 8 plus the addressing cost for a memory operand.
- R8: When opcode bit 8 is 1 (bit number from a register), the count is 6 for a register operand and 4 plus the addressing cost for a memory operand.
- R9: The program-counter step is 2 for the immediate form, which consumes one extension word, and 0 for the register form.
- R10: The bit-number register index output equals opcode bits 11:9, and the operand register index output equals opcode bits 2:0, in the same cycle as the opcode.
- R11: A request accepted on a rising edge shows its result with the valid output high after that edge. On a cycle with no request the valid output is low and the result, flags, count and step hold their previous values. After reset, valid and the write strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Request strobe |
| opcode | input | 16 | Instruction word |
| bit_num | input | 32 | Bit number (extension word or register contents) |
| operand | input | 32 | Operand value (register, or byte in bits 7:0) |
| ea_cost | input | 8 | Addressing cycle cost for a memory operand |
| flags_in | input | 5 | Incoming flags, Z at bit 2 |
| nsrc_reg | output | 3 | Index of the register holding the bit number |
| opnd_reg | output | 3 | Index of the operand register |
| out_valid | output | 1 | Result valid |
| out_flags | output | 5 | Flags with Z updated |
| out_result | output | 32 | Modified operand |
| out_wr_en | output | 1 | Write-back strobe |
| out_cycles | output | 8 | Execution cycle count |
| out_pc_step | output | 3 | Program-counter advance in bytes |

## Verification
Each result depends only on the request accepted on the previous edge, so a wrong mask index or a wrong operand width shows at the ports one cycle after the request. It appears as a wrong bit in the result or as an inverted Z, and with mixed bit numbers above 7 and above 31 the modulo rules are exposed at once. A fault in the output register's enable shows on the first idle cycle as a result that does not hold or a valid that does not drop. The cost and step paths are checked against the two bit-number sources and both operand types, so a swapped constant shows on the first request of the affected form.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  typedef enum logic [1:0] {
    OP_PROBE = 2'd0,
    OP_FLIP  = 2'd1,
    OP_CLEAR = 2'd2,
    OP_FORCE = 2'd3
  } bitop_e;

  localparam int FLAG_W   = 5;
  localparam int FLAG_ZPOS = 2;

  typedef struct packed {
    bitop_e     op;
    logic       regsrc;
    logic       is_reg;
    logic [2:0] mode;
    logic [2:0] opnd_reg;
    logic [2:0] nsrc_reg;
  } bitop_dec_t;

endpackage

// File: rtl/bitop_decode.sv
module bitop_decode
  import bitop_pkg::*;
(
  input  logic [15:0] opcode,
  output bitop_dec_t  dec
);

  always_comb begin
    dec.op       = bitop_e'(opcode[7:6]);
    dec.regsrc   = opcode[8];
    dec.mode     = opcode[5:3];
    dec.is_reg   = (opcode[5:3] == 3'd0);
    dec.opnd_reg = opcode[2:0];
    dec.nsrc_reg = opcode[11:9];
  end

endmodule

// File: rtl/bitop_mask.sv
module bitop_mask #(
  parameter int DATA_W = 32,
  parameter int MEM_W  = 8,
  parameter int NUM_W  = 32
) (
  input  logic [NUM_W-1:0]  bit_num,
  input  logic              is_reg,
  output logic [DATA_W-1:0] mask
);

  localparam int RIDX_W = $clog2(DATA_W);
  localparam int MIDX_W = $clog2(MEM_W);

  logic [RIDX_W-1:0] idx_reg;
  logic [MIDX_W-1:0] idx_mem;

  assign idx_reg = bit_num[RIDX_W-1:0];
  assign idx_mem = bit_num[MIDX_W-1:0];

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i < MEM_W) begin : g_low
      assign mask[i] = is_reg ? (idx_reg == RIDX_W'(i)) : (idx_mem == MIDX_W'(i));
    end else begin : g_high
      assign mask[i] = is_reg && (idx_reg == RIDX_W'(i));
    end
  end

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MEM_W  = 8
) (
  input  bitop_e            op,
  input  logic              is_reg,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              was_zero,
  output logic              wr_en
);

  logic [DATA_W-1:0] opnd_eff;

  always_comb begin
    if (is_reg) begin
      opnd_eff = operand;
    end else begin
      opnd_eff = '0;
      opnd_eff[MEM_W-1:0] = operand[MEM_W-1:0];
    end
  end

  assign was_zero = ~|(opnd_eff & mask);

  always_comb begin
    unique case (op)
      OP_FLIP:  result = opnd_eff ^ mask;
      OP_CLEAR: result = opnd_eff & ~mask;
      OP_FORCE: result = opnd_eff | mask;
      default:  result = opnd_eff;
    endcase
  end

  assign wr_en = (op != OP_PROBE);

endmodule

// File: rtl/bitop_cost.sv
module bitop_cost #(
  parameter int COST_W       = 8,
  parameter int STEP_W       = 3,
  parameter int IMM_REG_CYC  = 10,
  parameter int IMM_MEM_BASE = 8,
  parameter int RS_REG_CYC   = 6,
  parameter int RS_MEM_BASE  = 4,
  parameter int EXT_BYTES    = 2
) (
  input  logic              regsrc,
  input  logic              is_reg,
  input  logic [COST_W-1:0] ea_cost,
  output logic [COST_W-1:0] cycles,
  output logic [STEP_W-1:0] pc_step
);

  always_comb begin
    unique case ({regsrc, is_reg})
      2'b01:   cycles = COST_W'(IMM_REG_CYC);
      2'b00:   cycles = COST_W'(IMM_MEM_BASE) + ea_cost;
      2'b11:   cycles = COST_W'(RS_REG_CYC);
      default: cycles = COST_W'(RS_MEM_BASE) + ea_cost;
    endcase
  end

  assign pc_step = regsrc ? '0 : STEP_W'(EXT_BYTES);

endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MEM_W  = 8,
  parameter int NUM_W  = 32,
  parameter int COST_W = 8,
  parameter int STEP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [15:0]       opcode,
  input  logic [NUM_W-1:0]  bit_num,
  input  logic [DATA_W-1:0] operand,
  input  logic [COST_W-1:0] ea_cost,
  input  logic [4:0]        flags_in,
  output logic [2:0]        nsrc_reg,
  output logic [2:0]        opnd_reg,
  output logic              out_valid,
  output logic [4:0]        out_flags,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wr_en,
  output logic [COST_W-1:0] out_cycles,
  output logic [STEP_W-1:0] out_pc_step
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  bitop_dec_t        dec;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] res_c;
  logic              zero_c;
  logic              wr_c;
  logic [COST_W-1:0] cyc_c;
  logic [STEP_W-1:0] step_c;
  logic [4:0]        flags_c;

  logic              vld_d;
  logic              wr_d;
  logic [4:0]        flags_d;
  logic [DATA_W-1:0] res_d;
  logic [COST_W-1:0] cyc_d;
  logic [STEP_W-1:0] step_d;
  logic              take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  bitop_decode u_dec (
    .opcode (opcode),
    .dec    (dec)
  );

  bitop_mask #(.DATA_W(DATA_W), .MEM_W(MEM_W), .NUM_W(NUM_W)) u_mask (
    .bit_num (bit_num),
    .is_reg  (dec.is_reg),
    .mask    (mask)
  );

  bitop_alu #(.DATA_W(DATA_W), .MEM_W(MEM_W)) u_alu (
    .op       (dec.op),
    .is_reg   (dec.is_reg),
    .mask     (mask),
    .operand  (operand),
    .result   (res_c),
    .was_zero (zero_c),
    .wr_en    (wr_c)
  );

  bitop_cost #(.COST_W(COST_W), .STEP_W(STEP_W)) u_cost (
    .regsrc  (dec.regsrc),
    .is_reg  (dec.is_reg),
    .ea_cost (ea_cost),
    .cycles  (cyc_c),
    .pc_step (step_c)
  );

  assign nsrc_reg = dec.nsrc_reg;
  assign opnd_reg = dec.opnd_reg;

  always_comb begin
    flags_c            = flags_in;
    flags_c[FLAG_ZPOS] = zero_c;
  end

  assign take = in_valid;

  always_comb begin
    vld_d   = take;
    wr_d    = take && wr_c;
    flags_d = out_flags;
    res_d   = out_result;
    cyc_d   = out_cycles;
    step_d  = out_pc_step;
    if (take) begin
      flags_d = flags_c;
      res_d   = res_c;
      cyc_d   = cyc_c;
      step_d  = step_c;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid   <= 1'b0;
      out_wr_en   <= 1'b0;
      out_flags   <= '0;
      out_result  <= '0;
      out_cycles  <= '0;
      out_pc_step <= '0;
    end else begin
      out_valid   <= vld_d;
      out_wr_en   <= wr_d;
      out_flags   <= flags_d;
      out_result  <= res_d;
      out_cycles  <= cyc_d;
      out_pc_step <= step_d;
    end
  end

endmodule

// File: rtl/bitop_unit_chk.sv
module bitop_unit_chk #(
  parameter int DATA_W = 32,
  parameter int COST_W = 8,
  parameter int STEP_W = 3
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              in_valid,
  input logic [15:0]       opcode,
  input logic [4:0]        flags_in,
  input logic              out_valid,
  input logic [4:0]        out_flags,
  input logic [DATA_W-1:0] out_result,
  input logic              out_wr_en,
  input logic [COST_W-1:0] out_cycles,
  input logic [STEP_W-1:0] out_pc_step
);

  AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_valid); // R11

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> !out_valid && !out_wr_en); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !in_valid |=> $stable(out_result) && $stable(out_cycles) && $stable(out_flags)); // R11

  AST_PROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && opcode[7:6] == 2'd0 |=> !out_wr_en); // R6

  AST_MODIFY_WRITES: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && opcode[7:6] != 2'd0 |=> out_wr_en); // R6

  AST_OTHER_FLAGS_PASS: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_flags[4:3] == $past(flags_in[4:3]) && out_flags[1:0] == $past(flags_in[1:0])); // R2

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && opcode[5:3] != 3'd0 |=> out_result[DATA_W-1:8] == '0); // R1

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid |=> out_pc_step == ($past(opcode[8]) ? STEP_W'(0) : STEP_W'(2))); // R9

  AST_IMM_REG_COST: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && opcode[5:3] == 3'd0 && !opcode[8] |=> out_cycles == COST_W'(10)); // R7

  AST_RS_REG_COST: assert property (@(posedge clk) disable iff (!rst_ok)
    in_valid && opcode[5:3] == 3'd0 && opcode[8] |=> out_cycles == COST_W'(6)); // R8

endmodule

bind bitop_unit bitop_unit_chk #(.DATA_W(DATA_W), .COST_W(COST_W), .STEP_W(STEP_W)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_sync_n),
  .in_valid    (in_valid),
  .opcode      (opcode),
  .flags_in    (flags_in),
  .out_valid   (out_valid),
  .out_flags   (out_flags),
  .out_result  (out_result),
  .out_wr_en   (out_wr_en),
  .out_cycles  (out_cycles),
  .out_pc_step (out_pc_step)
);

// File: tb/bitop_unit_tb.sv
module bitop_unit_tb;

  typedef struct {
    logic [31:0] result;
    logic        wr;
    logic [4:0]  flags;
    logic [7:0]  cycles;
    logic [2:0]  step;
    logic [1:0]  op;
  } exp_t;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] opcode;
  logic [31:0] bit_num;
  logic [31:0] operand;
  logic [7:0]  ea_cost;
  logic [4:0]  flags_in;
  logic [2:0]  nsrc_reg;
  logic [2:0]  opnd_reg;
  logic        out_valid;
  logic [4:0]  out_flags;
  logic [31:0] out_result;
  logic        out_wr_en;
  logic [7:0]  out_cycles;
  logic [2:0]  out_pc_step;

  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;
  exp_t sb_q[$];
  logic [31:0] last_res;
  bit   have_last = 0;

  bitop_unit u_dut (
    .clk, .rst_n, .in_valid, .opcode, .bit_num, .operand, .ea_cost, .flags_in,
    .nsrc_reg, .opnd_reg, .out_valid, .out_flags, .out_result, .out_wr_en,
    .out_cycles, .out_pc_step
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input bit regsrc, input logic [2:0] mode,
                       input logic [2:0] oreg, input logic [2:0] breg, input logic [31:0] bn,
                       input logic [31:0] val, input logic [7:0] ea, input logic [4:0] fl);
    exp_t e;
    int idx;
    logic [31:0] v;
    logic [31:0] m;
    bit isr;
    isr = (mode == 3'd0);
    idx = isr ? int'(bn[4:0]) : int'(bn[2:0]);   // R1
    v   = isr ? val : {24'h0, val[7:0]};
    m   = 32'h1 << idx;
    case (op)
      2'd1: e.result = v ^ m;                     // R3
      2'd2: e.result = v & ~m;                    // R4
      2'd3: e.result = v | m;                     // R5
      default: e.result = v;                      // R6
    endcase
    e.wr    = (op != 2'd0);
    e.flags = fl;
    e.flags[2] = ((v & m) == 0);                  // R2
    if (!regsrc) e.cycles = isr ? 8'd10 : 8'd8 + ea;  // R7
    else         e.cycles = isr ? 8'd6  : 8'd4 + ea;  // R8
    e.step  = regsrc ? 3'd0 : 3'd2;               // R9
    e.op    = op;
    @(negedge clk);
    in_valid = 1'b1;
    opcode   = {4'h0, breg, regsrc, op, mode, oreg};
    bit_num  = bn;
    operand  = val;
    ea_cost  = ea;
    flags_in = fl;
    sb_q.push_back(e);
    #1;
    chk(nsrc_reg == breg && opnd_reg == oreg, "R10", {26'h0, nsrc_reg, opnd_reg}, {26'h0, breg, oreg});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R11 unexpected valid", 32'h1, 32'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          case (e.op)
            2'd1: chk(out_result == e.result, "R3 result", out_result, e.result);
            2'd2: chk(out_result == e.result, "R4 result", out_result, e.result);
            2'd3: chk(out_result == e.result, "R5 result", out_result, e.result);
            default: chk(out_result == e.result, "R6 result", out_result, e.result);
          endcase
          chk(out_wr_en == e.wr, "R6 write strobe", {31'h0, out_wr_en}, {31'h0, e.wr});
          chk(out_flags == e.flags, "R2 flags", {27'h0, out_flags}, {27'h0, e.flags});
          chk(out_cycles == e.cycles, "R7/R8 cycles", {24'h0, out_cycles}, {24'h0, e.cycles});
          chk(out_pc_step == e.step, "R9 pc step", {29'h0, out_pc_step}, {29'h0, e.step});
        end
        last_res  = out_result;
        have_last = 1;
      end else if (have_last) begin
        chk(out_result == last_res && !out_wr_en, "R11 hold", out_result, last_res);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; bit_num = '0;
    operand = '0; ea_cost = '0; flags_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0 && out_wr_en == 1'b0, "R11 reset state", {31'h0, out_valid}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R11 after release", {31'h0, out_valid}, 32'h0);

    // R1: register operand, bit 37 -> index 5; memory bit 13 -> index 5 of byte
    drive(2'd3, 1'b0, 3'd0, 3'd1, 3'd2, 32'd37, 32'h0000_0000, 8'd0, 5'b10101);
    drive(2'd3, 1'b0, 3'd2, 3'd3, 3'd4, 32'd13, 32'hFFFF_FF00, 8'd4, 5'b00000);
    // R2: Z from bit before change, other flags kept
    drive(2'd1, 1'b1, 3'd0, 3'd7, 3'd5, 32'd31, 32'h8000_0000, 8'd0, 5'b11111);
    drive(2'd1, 1'b1, 3'd0, 3'd0, 3'd6, 32'd31, 32'h0000_0000, 8'd0, 5'b11011);
    // R4 clear on register and on memory byte, R8 memory cost
    drive(2'd2, 1'b1, 3'd0, 3'd2, 3'd1, 32'd16, 32'hFFFF_FFFF, 8'd9, 5'b00100);
    drive(2'd2, 1'b1, 3'd5, 3'd2, 3'd1, 32'd7,  32'h1234_56FF, 8'd8, 5'b01000);
    // R6 test leaves operand and does not write
    drive(2'd0, 1'b0, 3'd0, 3'd4, 3'd3, 32'd0, 32'hDEAD_BEEF, 8'd0, 5'b00011);
    drive(2'd0, 1'b0, 3'd7, 3'd1, 3'd0, 32'hFFFF_FFF8, 32'hAAAA_AA55, 8'd12, 5'b10000);
    idle(3);
    // R11 back-to-back then idle hold
    drive(2'd1, 1'b0, 3'd3, 3'd6, 3'd7, 32'd200, 32'h0000_0081, 8'd6, 5'b01010);
    drive(2'd3, 1'b1, 3'd0, 3'd5, 3'd2, 32'd255, 32'h7FFF_FFFF, 8'd0, 5'b00101);
    idle(2);

    for (int k = 0; k < 300; k++) begin
      logic [2:0] md;
      md = ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom_range(2, 7));
      drive(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), md,
            3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), $urandom,
            $urandom, 8'($urandom_range(0, 20)), 5'($urandom_range(0, 31)));
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(3);
    chk(sb_q.size() == 0, "R11 all results returned", sb_q.size(), 32'h0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule